// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading a two-level page table held in memory. A requester, typically the miss path of a translation cache, hands over a virtual address together with the physical base of the current first-level table. The walker then reads one table entry per level over a single-read-at-a-time memory port. At the first level the entry points to a second-level table. At the second level the entry gives the physical page number.

Every entry carries a valid flag in bit 0 and a 20-bit page or table base number in bits 31:12. Bits 11:1 hold flags that the walker passes through untouched. If the entry read at either level has its valid flag clear, the walk ends at once with a fault. A successful walk returns the physical address and the complete leaf entry, so that the requester can fill its cache. The request side uses a valid/ready handshake and accepts work only while the walker is idle. A result appears as a one-cycle pulse on `done`.

The address splits as follows. The first-level index is bits 31:22, the second-level index is bits 21:12, and the page offset is bits 11:0. Entries are four bytes wide.

Top module: `page_walker`

## Requirements
- R1: During and right after a synchronous active-low reset, `done`, `fault` and `mem_req` are 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only while the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and while a walk is in progress `req_ready` stays 0.
- R3: In the cycle after acceptance, `mem_req` pulses for one cycle. `mem_addr` is then `table_root + 4 * vaddr[31:22]`.
- R4: After a valid first-level entry E1, the second read goes to `{E1[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R5: At most one read is outstanding. Once `mem_req` has pulsed, it stays 0 until `mem_rvalid` returns, however many cycles that takes.
- R6: A first-level entry with bit 0 = 0 ends the walk. One cycle after the response, `done` = 1 and `fault` = 1, with `paddr` = 0 and `leaf_pte` = 0, and no second read is issued.
- R7: A second-level entry with bit 0 = 0 ends the walk the same way, with `fault` = 1, `paddr` = 0 and `leaf_pte` = 0.
- R8: A valid second-level entry E2 gives `done` = 1 and `fault` = 0 one cycle after the response. In that cycle `paddr` = `{E2[31:12], vaddr[11:0]}` and `leaf_pte` = E2, with flag bits 11:1 kept unchanged.
- R9: `done` lasts exactly one cycle per walk, and `fault` is never 1 without `done`.
- R10: A `mem_rvalid` pulse while no read is outstanding is ignored: no result, no read, and no change to the next walk.
- R11: A request held on `req_valid` is accepted in the same cycle that `done` pulses for the previous walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| table_root | input | 32 | Physical byte address of the first-level table, sampled at acceptance |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle result pulse |
| fault | output | 1 | With `done`: the walk hit an invalid entry |
| paddr | output | 32 | Translated physical address, 0 on fault |
| leaf_pte | output | 32 | Second-level entry on success, 0 on fault |

## Verification
The result pulse of one walk and the acceptance of the next request can fall in the same cycle, because the walker goes idle on the edge that raises `done`. The bench provokes this by issuing a second request straight after the first, so that `req_valid` is held high through a walk with a slow memory. It then judges the overlap in two ways. It watches for a cycle in which `done`, `req_valid` and `req_ready` are all high. It also confirms through the scoreboard that both walks return the right results and that their reads reach memory in order, at the addresses the bench computes itself.

// File: rtl/page_walker_pkg.sv
// Shared definitions for the two-level page walker.
// Assumes nothing beyond a synthesizable enum encoding.
package page_walker_pkg;

    // Walk sequencing states: an issue state per level, then a wait state per level
    typedef enum logic [2:0] {
        WS_IDLE   = 3'd0,
        WS_ISSUE1 = 3'd1,
        WS_WAIT1  = 3'd2,
        WS_ISSUE2 = 3'd3,
        WS_WAIT2  = 3'd4
    } walk_state_e;

    // Bit of an entry that marks it present
    localparam int unsigned ENTRY_VALID_BIT = 0;

endpackage

// File: rtl/page_walker_addr.sv
// Entry address former: selects the table base for the current level and
// adds the scaled index. Assumes IDX_W + ENTRY_LOG2 <= OFS_W so a second-level
// table fits inside one page-aligned region.
module page_walker_addr #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned OFS_W      = 12,
    parameter int unsigned IDX_W      = 10,
    parameter int unsigned ENTRY_LOG2 = 2
) (
    input  logic                    second_level,
    input  logic [ADDR_W-1:0]       root_base,
    input  logic [ADDR_W-OFS_W-1:0] next_table_num,
    input  logic [IDX_W-1:0]        idx_l1,
    input  logic [IDX_W-1:0]        idx_l2,
    output logic [ADDR_W-1:0]       entry_addr
);
    localparam int unsigned NUM_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] base_sel;
    logic [ADDR_W-1:0] idx_ext;

    // Pick the table base and widen the index of the active level
    always_comb begin : pick_base
        if (second_level) begin
            base_sel = {next_table_num, {OFS_W{1'b0}}};
            idx_ext  = {{(ADDR_W-IDX_W){1'b0}}, idx_l2};
        end else begin
            base_sel = root_base;
            idx_ext  = {{(ADDR_W-IDX_W){1'b0}}, idx_l1};
        end
    end

    // Entry address is base plus index times entry size
    always_comb begin : form_addr
        entry_addr = base_sel + (idx_ext << ENTRY_LOG2);
    end

    if (NUM_W + OFS_W != ADDR_W) begin : g_bad_split
        $error("page_walker_addr: inconsistent address split");
    end
endmodule

// File: rtl/page_walker_ctrl.sv
// Walk sequencer: accepts a request when idle, issues one read per level,
// waits any number of cycles for each response, checks the valid bit and
// produces a one-cycle result. Assumes the response never arrives in the
// same cycle as its request and that memory keeps a single read in flight.
module page_walker_ctrl
    import page_walker_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned IDX_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_vaddr,
    input  logic [ADDR_W-1:0]       table_root,
    output logic                    req_ready,
    input  logic                    mem_rvalid,
    input  logic [ADDR_W-1:0]       mem_rdata,
    output logic                    mem_req,
    output logic                    second_level,
    output logic [ADDR_W-1:0]       root_q,
    output logic [ADDR_W-OFS_W-1:0] next_num_q,
    output logic [IDX_W-1:0]        idx_l1,
    output logic [IDX_W-1:0]        idx_l2,
    output logic                    done,
    output logic                    fault,
    output logic [ADDR_W-1:0]       paddr,
    output logic [ADDR_W-1:0]       leaf_pte
);
    localparam int unsigned NUM_W = ADDR_W - OFS_W;

    walk_state_e       state_q, state_d;
    logic [ADDR_W-1:0] vaddr_q;
    logic              entry_ok;
    logic [NUM_W-1:0]  entry_num;
    logic              accept;

    // Field extraction from the returned entry
    always_comb begin : split_entry
        entry_ok  = mem_rdata[ENTRY_VALID_BIT];
        entry_num = mem_rdata[ADDR_W-1 -: NUM_W];
    end

    // Handshake and read strobe derived from the state
    always_comb begin : port_strobes
        req_ready    = (state_q == WS_IDLE);
        accept       = req_ready && req_valid;
        mem_req      = (state_q == WS_ISSUE1) || (state_q == WS_ISSUE2);
        second_level = (state_q == WS_ISSUE2) || (state_q == WS_WAIT2);
        idx_l1       = vaddr_q[OFS_W+2*IDX_W-1 -: IDX_W];
        idx_l2       = vaddr_q[OFS_W+IDX_W-1 -: IDX_W];
    end

    // Next-state selection, with the early exit on an invalid first-level entry
    always_comb begin : next_state
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:   if (req_valid) state_d = WS_ISSUE1;
            WS_ISSUE1: state_d = WS_WAIT1;
            WS_WAIT1:  if (mem_rvalid) state_d = entry_ok ? WS_ISSUE2 : WS_IDLE;
            WS_ISSUE2: state_d = WS_WAIT2;
            WS_WAIT2:  if (mem_rvalid) state_d = WS_IDLE;
            default:   state_d = WS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin : state_reg
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // Capture the request and the next-level table base
    always_ff @(posedge clk) begin : walk_context
        if (!rst_n) begin
            vaddr_q    <= '0;
            root_q     <= '0;
            next_num_q <= '0;
        end else begin
            if (accept) begin
                vaddr_q <= req_vaddr;
                root_q  <= table_root;
            end
            if (state_q == WS_WAIT1 && mem_rvalid && entry_ok)
                next_num_q <= entry_num;
        end
    end

    // One-cycle result with fault or translated address
    always_ff @(posedge clk) begin : result_regs
        if (!rst_n) begin
            done     <= 1'b0;
            fault    <= 1'b0;
            paddr    <= '0;
            leaf_pte <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            if (state_q == WS_WAIT1 && mem_rvalid && !entry_ok) begin
                done     <= 1'b1;
                fault    <= 1'b1;
                paddr    <= '0;
                leaf_pte <= '0;
            end else if (state_q == WS_WAIT2 && mem_rvalid) begin
                done     <= 1'b1;
                fault    <= !entry_ok;
                paddr    <= entry_ok ? {entry_num, vaddr_q[OFS_W-1:0]} : '0;
                leaf_pte <= entry_ok ? mem_rdata : '0;
            end
        end
    end

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !mem_req); // R2
    AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> mem_req); // R3
    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req); // R5
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_FAULT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) fault |-> done); // R9
    AST_STRAY_RESPONSE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (req_ready && !req_valid && mem_rvalid) |=> (!done && !mem_req)); // R10
endmodule

// File: rtl/page_walker.sv
// Two-level page table walker top: joins the walk sequencer and the entry
// address former. Assumes ADDR_W = OFS_W + 2*IDX_W and entries of
// 2**ENTRY_LOG2 bytes whose upper ADDR_W-OFS_W bits hold a base number.
module page_walker #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned OFS_W      = 12,
    parameter int unsigned IDX_W      = 10,
    parameter int unsigned ENTRY_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] table_root,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [ADDR_W-1:0] paddr,
    output logic [ADDR_W-1:0] leaf_pte
);
    localparam int unsigned NUM_W = ADDR_W - OFS_W;

    logic              second_level;
    logic [ADDR_W-1:0] root_q;
    logic [NUM_W-1:0]  next_num_q;
    logic [IDX_W-1:0]  idx_l1;
    logic [IDX_W-1:0]  idx_l2;

    page_walker_ctrl #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .table_root   (table_root),
        .req_ready    (req_ready),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .mem_req      (mem_req),
        .second_level (second_level),
        .root_q       (root_q),
        .next_num_q   (next_num_q),
        .idx_l1       (idx_l1),
        .idx_l2       (idx_l2),
        .done         (done),
        .fault        (fault),
        .paddr        (paddr),
        .leaf_pte     (leaf_pte)
    );

    page_walker_addr #(
        .ADDR_W     (ADDR_W),
        .OFS_W      (OFS_W),
        .IDX_W      (IDX_W),
        .ENTRY_LOG2 (ENTRY_LOG2)
    ) u_addr (
        .second_level   (second_level),
        .root_base      (root_q),
        .next_table_num (next_num_q),
        .idx_l1         (idx_l1),
        .idx_l2         (idx_l2),
        .entry_addr     (mem_addr)
    );

    if (ADDR_W != OFS_W + 2*IDX_W) begin : g_bad_geometry
        $error("page_walker: ADDR_W must equal OFS_W + 2*IDX_W");
    end
endmodule

// File: tb/page_walker_test.sv
// Scoreboard bench: the driver computes each walk's reads and result from a
// bench-side memory model and queues them; the responder and the monitor
// pop and compare as the walker acts.
module page_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] table_root = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        rsp_valid = 1'b0;
    logic        stray_valid = 1'b0;
    logic        mem_rvalid;
    logic [31:0] mem_rdata = '0;
    logic        done, fault;
    logic [31:0] paddr, leaf_pte;

    int checks = 0;
    int fails = 0;
    int lat = 1;
    int overlap = 0;
    bit finished = 1'b0;

    logic [31:0] pmem [logic [31:0]];
    logic [31:0] addr_q [$];
    string       atag_q [$];
    logic [64:0] res_q [$];
    string       rtag_q [$];

    assign mem_rvalid = rsp_valid | stray_valid;

    always #5 clk = ~clk;

    page_walker uut (
        .clk(clk), .rst_n(rst_n), .table_root(table_root),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .paddr(paddr), .leaf_pte(leaf_pte)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: computes expectations, queues them, then performs the handshake
    task automatic drive(input logic [31:0] va, input logic [31:0] root);
        logic [31:0] a1, a2, e1, e2;
        a1 = root + {20'h0, va[31:22], 2'b00};
        e1 = rd(a1);
        addr_q.push_back(a1); atag_q.push_back("R3");
        if (!e1[0]) begin
            res_q.push_back({1'b1, 32'h0, 32'h0}); rtag_q.push_back("R6");
        end else begin
            a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
            e2 = rd(a2);
            addr_q.push_back(a2); atag_q.push_back("R4");
            if (!e2[0]) begin
                res_q.push_back({1'b1, 32'h0, 32'h0}); rtag_q.push_back("R7");
            end else begin
                res_q.push_back({1'b0, e2[31:12], va[11:0], e2}); rtag_q.push_back("R8");
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; table_root = root;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Memory responder: checks each read address and keeps reads single (R5)
    initial begin : responder
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (mem_req) begin
                logic [31:0] a;
                bit quiet;
                a = mem_addr;
                if (addr_q.size() == 0) begin
                    check(1'b0, "R3 unexpected read", a, 32'h0);
                end else begin
                    logic [31:0] ea;
                    string t;
                    ea = addr_q.pop_front();
                    t = atag_q.pop_front();
                    check(a == ea, {t, " read address"}, a, ea);
                end
                quiet = 1'b1;
                for (int i = 0; i <= lat; i++) begin
                    @(negedge clk);
                    if (mem_req) quiet = 1'b0;
                end
                check(quiet, "R5 second read while one outstanding", {31'h0, quiet}, 32'h1);
                mem_rdata = rd(a);
                rsp_valid = 1'b1;
            end
        end
    end

    // Monitor: compares each result pulse with the scoreboard (R6 R7 R8 R9 R11)
    initial begin : monitor
        bit prev_done;
        prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (fault && !done) check(1'b0, "R9 fault without done", 32'h1, 32'h0);
                if (done && prev_done) check(1'b0, "R9 done longer than one cycle", 32'h1, 32'h0);
                if (done) begin
                    if (req_valid && req_ready) overlap++;
                    if (res_q.size() == 0) begin
                        check(1'b0, "R9 unexpected result", paddr, 32'h0);
                    end else begin
                        logic [64:0] r;
                        string t;
                        r = res_q.pop_front();
                        t = rtag_q.pop_front();
                        check(fault == r[64], {t, " fault flag"}, {31'h0, fault}, {31'h0, r[64]});
                        check(paddr == r[63:32], {t, " physical address"}, paddr, r[63:32]);
                        check(leaf_pte == r[31:0], {t, " leaf entry"}, leaf_pte, r[31:0]);
                    end
                end
                prev_done = done;
            end
        end
    end

    task automatic drain();
        while (res_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stimulus
        pmem[32'h0001_0004] = 32'h0002_0001;
        pmem[32'h0002_000C] = 32'h0ABC_D0E3;
        pmem[32'h0002_0040] = 32'h1234_5000;
        pmem[32'h0001_0FFC] = 32'h0003_0001;
        pmem[32'h0003_0FFC] = 32'hFFFF_F001;
        pmem[32'h0005_0000] = 32'h0006_0001;
        pmem[32'h0006_0000] = 32'h0000_1FFF;

        // R1: outputs quiet during reset and ready right after
        repeat (3) @(negedge clk);
        check(!done && !fault && !mem_req, "R1 outputs during reset", {29'h0, done, fault, mem_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", {31'h0, req_ready}, 32'h1);
        check(!done && !fault, "R1 no result after reset", {30'h0, done, fault}, 32'h0);

        // R8: successful walk, minimum latency
        lat = 0;
        drive(32'h0040_3ABC, 32'h0001_0000);
        drain();

        // R2: ready stays low while a slow walk is in flight
        lat = 6;
        drive(32'hFFFF_FFFF, 32'h0001_0000);
        @(negedge clk);
        check(req_ready == 1'b0, "R2 ready during walk", {31'h0, req_ready}, 32'h0);
        drain();

        // R6: invalid first-level entry, R7: invalid second-level entry
        lat = 2;
        drive(32'h0080_0123, 32'h0001_0000);
        drain();
        drive(32'h0041_0456, 32'h0001_0000);
        drain();

        // R10: stray response in idle has no effect
        @(negedge clk);
        stray_valid = 1'b1; mem_rdata = 32'hFFFF_FFFF;
        @(negedge clk);
        stray_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(!done && !mem_req, "R10 stray response ignored", {30'h0, done, mem_req}, 32'h0);
            @(negedge clk);
        end
        // R8 with all flag bits set and a different root, right after the stray pulse
        lat = 1;
        drive(32'h0000_0000, 32'h0005_0000);
        drain();

        // R11: back-to-back requests, second accepted on the result cycle
        lat = 4;
        drive(32'h0040_3ABC, 32'h0001_0000);
        drive(32'h0041_0456, 32'h0001_0000);
        drive(32'hFFFF_FFFF, 32'h0001_0000);
        drain();
        check(overlap >= 2, "R11 accept during done", overlap, 2);
        check(res_q.size() == 0 && addr_q.size() == 0, "R9 all results returned",
              res_q.size() + addr_q.size(), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule